// File: doc/BRIEF.md
# Four-Bank Row Cache Tracker

This block tracks which row each of four internal banks of a cached DRAM currently holds in its row register. It takes a multiplexed row address and a column address. Two row-address bits pick the bank, and the other row bits form a tag. The tag is compared with the last row read into that bank's register, and each accepted access is reported as a hit or a miss one cycle later.

- A read hit returns the cached word.
- A read miss loads the new tag, pulses a fill request, and copies the row out of a small backing array one word per cycle. The block reports itself busy during the copy.
- A write always goes to the backing array. It also goes to the cached row only when it hits.

The backing array is a reduced model. Each bank keeps `2^ARR_ROW_W` rows, and a row tag selects its array row through the tag's low `ARR_ROW_W` bits. The array starts from a computed pattern at reset.

A requester holds a request on `req_valid` with `sel` high and watches `hit`/`miss`. After a read miss it waits until `busy` falls and then reissues the read.

Top module: `row_cache_ctl`

## Requirements
- R1: The bank number is `{row_addr[2], row_addr[9]}`, so bits (2,9) = (0,0), (0,1), (1,0), (1,1) select banks 0, 1, 2, 3. The tag is the remaining nine row bits, placed in ascending order into tag bits 0..8.
- R2: During and after reset, `hit`, `miss`, `fill_req`, `illegal`, `rdata_valid` and `busy` are low. The first access to each bank after reset is a miss.
- R3: An access is accepted when `req_valid` and `sel` are high and `busy` is low. For an accepted read whose tag equals the addressed bank's valid tag, `hit` and `rdata_valid` are high in the next cycle and `rdata` holds the cached word at `col_addr`. `hit` and `miss` are never high together.
- R4: An accepted read that misses raises `miss` and `fill_req` for one cycle and raises `busy` in the same cycle. `busy` stays high for exactly `2^COL_W` cycles while the array row is copied into that bank's register. The bank's tag becomes the new row.
- R5: A miss or fill in one bank leaves the tags and data of the other three banks unchanged, so those banks keep hitting.
- R6: A write that misses updates the backing array only. No cache register's tag or data changes.
- R7: A write that hits updates both the cached word and the array word, so a later read hit, or a later refill of that row, returns the written value.
- R8: When `req_valid` is high and `sel` is low, `illegal` is high in the next cycle. The request raises neither `hit` nor `miss` and changes no state.
- R9: While `busy` is high, requests are ignored: no strobes, no writes, no tag changes.
- R10: After reset, array word `(bank b, array row r, column c)` equals `(PAT_SEED + PAT_MUL*((b<<(ARR_ROW_W+COL_W)) | (r<<COL_W) | c)) mod 2^DATA_W`, where `r` is the tag's low `ARR_ROW_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Row strobe: access request |
| sel | input | 1 | Chip select; must be high with req_valid |
| we | input | 1 | 1 = write, 0 = read |
| row_addr | input | ROW_W (11) | Multiplexed row address |
| col_addr | input | COL_W (9) | Column address within the row |
| wdata | input | DATA_W (36) | Write data |
| hit | output | 1 | One-cycle hit strobe |
| miss | output | 1 | One-cycle miss strobe |
| fill_req | output | 1 | One-cycle row fill request |
| busy | output | 1 | Row fill in progress; requests stalled |
| illegal | output | 1 | Row strobe seen without chip select |
| rdata_valid | output | 1 | rdata holds read-hit data |
| rdata | output | DATA_W (36) | Read data |

## Verification
The hardest situation to reach is a write miss whose aliased array row is later refilled into a bank that still holds a different cached copy. At that point the cache and array legitimately disagree until the eviction.

The stimulus reaches it in a fixed sequence:
1. Fill a row.
2. Write-hit it.
3. Write-miss a second tag of the same bank that maps to the same array row.
4. Confirm the first row still hits with its old data.
5. Read the second tag so that the refill picks up the write-miss value.

Requests issued while a fill is in progress, and strobes without chip select, are then mixed in with random traffic over a small tag set. A behavioural model follows the bank registers and the array and is compared on every cycle.

// File: rtl/row_cache_pkg.sv
package row_cache_pkg;
   localparam int NBANK  = 4;
   localparam int BANK_W = 2;

   // Initial content of the backing array: affine in the flat word index.
   function automatic logic [63:0] init_word(input logic [63:0] seed,
                                             input logic [63:0] mul,
                                             input logic [63:0] idx);
      return seed + mul * idx;
   endfunction
endpackage

// File: rtl/rc_decode.sv
module rc_decode #(
   parameter int ROW_W   = 11,
   parameter int BANK_LO = 2,
   parameter int BANK_HI = 9,
   localparam int TAG_W  = ROW_W - 2
) (
   input  logic [ROW_W-1:0] row,
   output logic [1:0]       bank,
   output logic [TAG_W-1:0] tag
);
   assign bank = {row[BANK_LO], row[BANK_HI]};

   // Every non-bank bit moves down by the number of bank bits below it.
   for (genvar i = 0; i < ROW_W; i++) begin : g_bit
      if (i != BANK_LO && i != BANK_HI) begin : g_keep
         localparam int POS = i - ((i > BANK_LO) ? 1 : 0) - ((i > BANK_HI) ? 1 : 0);
         assign tag[POS] = row[i];
      end
   end
endmodule

// File: rtl/rc_tag_store.sv
module rc_tag_store #(
   parameter int TAG_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bank,
   input  logic [TAG_W-1:0] tag,
   input  logic             load,
   output logic             hit
);
   import row_cache_pkg::*;
   logic [NBANK-1:0] hit_vec;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [TAG_W-1:0] tag_q;
      logic             valid_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q   <= '0;
            valid_q <= 1'b0;
         end else if (load && bank == BANK_W'(b)) begin
            tag_q   <= tag;
            valid_q <= 1'b1;
         end
      end
      assign hit_vec[b] = valid_q && (tag_q == tag);
   end

   assign hit = hit_vec[bank];
endmodule

// File: rtl/rc_data_store.sv
module rc_data_store #(
   parameter int COL_W     = 9,
   parameter int DATA_W    = 36,
   parameter int ARR_ROW_W = 1,
   parameter logic [63:0] PAT_SEED = 64'h5A5,
   parameter logic [63:0] PAT_MUL  = 64'h9E3779B1,
   localparam int CA_W  = 2 + COL_W,
   localparam int AA_W  = 2 + ARR_ROW_W + COL_W,
   localparam int CSIZE = 1 << CA_W,
   localparam int ASIZE = 1 << AA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              c_we,
   input  logic [CA_W-1:0]   c_waddr,
   input  logic [DATA_W-1:0] c_wdata,
   input  logic [CA_W-1:0]   c_raddr,
   output logic [DATA_W-1:0] c_rdata,
   input  logic              a_we,
   input  logic [AA_W-1:0]   a_waddr,
   input  logic [DATA_W-1:0] a_wdata,
   input  logic [AA_W-1:0]   a_raddr,
   output logic [DATA_W-1:0] a_rdata
);
   import row_cache_pkg::*;
   logic [DATA_W-1:0] cache_mem [CSIZE];
   logic [DATA_W-1:0] arr_mem   [ASIZE];

   always_ff @(posedge clk) begin
      if (c_we) cache_mem[c_waddr] <= c_wdata;
      c_rdata <= cache_mem[c_raddr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ASIZE; i++)
            arr_mem[i] <= DATA_W'(init_word(PAT_SEED, PAT_MUL, 64'(i)));
      end else if (a_we) begin
         arr_mem[a_waddr] <= a_wdata;
      end
   end

   assign a_rdata = arr_mem[a_raddr];
endmodule

// File: rtl/row_cache_ctl.sv
module row_cache_ctl #(
   parameter int ROW_W     = 11,
   parameter int COL_W     = 9,
   parameter int DATA_W    = 36,
   parameter int BANK_LO   = 2,
   parameter int BANK_HI   = 9,
   parameter int ARR_ROW_W = 1,
   parameter logic [63:0] PAT_SEED = 64'h5A5,
   parameter logic [63:0] PAT_MUL  = 64'h9E3779B1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              sel,
   input  logic              we,
   input  logic [ROW_W-1:0]  row_addr,
   input  logic [COL_W-1:0]  col_addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              hit,
   output logic              miss,
   output logic              fill_req,
   output logic              busy,
   output logic              illegal,
   output logic              rdata_valid,
   output logic [DATA_W-1:0] rdata
);
   localparam int TAG_W = ROW_W - 2;
   localparam int CA_W  = 2 + COL_W;
   localparam int AA_W  = 2 + ARR_ROW_W + COL_W;

   if (BANK_LO >= BANK_HI || BANK_HI >= ROW_W) begin : g_bad_bank
      $error("row_cache_ctl: bank bits must satisfy BANK_LO < BANK_HI < ROW_W");
   end
   if (ARR_ROW_W < 1 || ARR_ROW_W > TAG_W) begin : g_bad_arr
      $error("row_cache_ctl: ARR_ROW_W must be in 1..TAG_W");
   end

   logic [1:0]       bank;
   logic [TAG_W-1:0] tag;
   logic             tag_hit, accept, load;
   logic             busy_q, hit_q, miss_q, fill_q, ill_q, rv_q;
   logic [COL_W-1:0] cnt_q;
   logic [1:0]       fbank_q;
   logic [ARR_ROW_W-1:0] frow_q;
   logic             c_we;
   logic [CA_W-1:0]  c_waddr;
   logic [DATA_W-1:0] c_wdata, a_rdata;

   rc_decode #(.ROW_W(ROW_W), .BANK_LO(BANK_LO), .BANK_HI(BANK_HI)) u_dec (
      .row(row_addr), .bank(bank), .tag(tag));

   rc_tag_store #(.TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .bank(bank), .tag(tag), .load(load), .hit(tag_hit));

   assign accept = req_valid && sel && !busy_q;
   assign load   = accept && !we && !tag_hit;

   always_comb begin
      if (busy_q) begin
         c_we    = 1'b1;
         c_waddr = {fbank_q, cnt_q};
         c_wdata = a_rdata;
      end else begin
         c_we    = accept && we && tag_hit;
         c_waddr = {bank, col_addr};
         c_wdata = wdata;
      end
   end

   rc_data_store #(.COL_W(COL_W), .DATA_W(DATA_W), .ARR_ROW_W(ARR_ROW_W),
                   .PAT_SEED(PAT_SEED), .PAT_MUL(PAT_MUL)) u_data (
      .clk(clk), .rst_n(rst_n),
      .c_we(c_we), .c_waddr(c_waddr), .c_wdata(c_wdata),
      .c_raddr({bank, col_addr}), .c_rdata(rdata),
      .a_we(accept && we), .a_waddr({bank, tag[ARR_ROW_W-1:0], col_addr}), .a_wdata(wdata),
      .a_raddr(AA_W'({fbank_q, frow_q, cnt_q})), .a_rdata(a_rdata));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         fbank_q <= '0;
         frow_q  <= '0;
         hit_q   <= 1'b0;
         miss_q  <= 1'b0;
         fill_q  <= 1'b0;
         ill_q   <= 1'b0;
         rv_q    <= 1'b0;
      end else begin
         hit_q  <= accept && tag_hit;
         miss_q <= accept && !tag_hit;
         fill_q <= load;
         rv_q   <= accept && !we && tag_hit;
         ill_q  <= req_valid && !sel;
         if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == {COL_W{1'b1}}) busy_q <= 1'b0;
         end else if (load) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            fbank_q <= bank;
            frow_q  <= tag[ARR_ROW_W-1:0];
         end
      end
   end

   assign hit         = hit_q;
   assign miss        = miss_q;
   assign fill_req    = fill_q;
   assign busy        = busy_q;
   assign illegal     = ill_q;
   assign rdata_valid = rv_q;
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
   parameter int COL_W = 9
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic sel,
   input logic hit,
   input logic miss,
   input logic fill_req,
   input logic busy,
   input logic illegal,
   input logic rdata_valid
);
   localparam int WORDS = 1 << COL_W;
   int unsigned run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) run_len <= 0;
      else if (busy) run_len <= run_len + 1;
      else run_len <= 0;
   end

   a_r3_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && miss));
   a_r3_data_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_valid |-> hit);
   a_r4_fill_is_miss: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> (miss && busy));
   a_r4_fill_length: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fill_req && run_len == WORDS) |-> 1'b0);
   a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !sel) |=> (illegal && !hit && !miss));
   a_r9_no_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fill_req) |-> (!hit && !miss));
endmodule

bind row_cache_ctl rc_checker #(.COL_W(COL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sel(sel),
   .hit(hit), .miss(miss), .fill_req(fill_req), .busy(busy),
   .illegal(illegal), .rdata_valid(rdata_valid));

// File: tb/row_cache_ctl_bench.sv
`timescale 1ns/1ps
module row_cache_ctl_bench;
   localparam int COL_W = 9, DATA_W = 36, AR = 1;
   localparam int WORDS = 1 << COL_W;
   localparam logic [63:0] SEED = 64'h5A5, MUL = 64'h9E3779B1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, sel = 0, we = 0;
   logic [10:0] row_addr = '0;
   logic [8:0]  col_addr = '0;
   logic [35:0] wdata = '0;
   logic hit, miss, fill_req, busy, illegal, rdata_valid;
   logic [35:0] rdata;

   int total = 0, bad = 0;

   // behavioural model
   logic [35:0] m_arr [int];
   logic [35:0] m_cache [int];
   logic [8:0]  m_tag [4];
   bit          m_val [4];
   int busy_cnt = 0, fill_idx = 0, f_bank = 0, f_arow = 0;
   bit e_hit, e_miss, e_fill, e_ill, e_rv;
   logic [35:0] e_rdata;

   always #2.5 clk = ~clk;

   row_cache_ctl u_row_cache_ctl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sel(sel), .we(we),
      .row_addr(row_addr), .col_addr(col_addr), .wdata(wdata),
      .hit(hit), .miss(miss), .fill_req(fill_req), .busy(busy),
      .illegal(illegal), .rdata_valid(rdata_valid), .rdata(rdata));

   function automatic logic [10:0] mkrow(input int b, input int t);
      logic [10:0] r;
      int k = 0;
      for (int i = 0; i < 11; i++) begin
         if (i == 2) r[i] = b[1];
         else if (i == 9) r[i] = b[0];
         else begin r[i] = t[k]; k++; end
      end
      return r;
   endfunction

   function automatic int aidx(input int b, input int ar, input int c);
      return (b << (AR + COL_W)) | (ar << COL_W) | c;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare();
      chk("R3", "hit", 64'(hit), 64'(e_hit));
      chk("R4", "miss", 64'(miss), 64'(e_miss));
      chk("R4", "fill_req", 64'(fill_req), 64'(e_fill));
      chk("R9", "busy", 64'(busy), 64'(busy_cnt > 0));
      chk("R8", "illegal", 64'(illegal), 64'(e_ill));
      chk("R3", "rdata_valid", 64'(rdata_valid), 64'(e_rv));
      if (e_rv) chk("R7", "rdata", 64'(rdata), 64'(e_rdata));
   endtask

   task automatic model(input bit r, input bit s, input bit w,
                        input logic [10:0] row, input logic [8:0] col, input logic [35:0] wd);
      int b, t, k, ar;
      bit h;
      e_hit = 0; e_miss = 0; e_fill = 0; e_rv = 0;
      e_ill = r && !s;
      b = {row[2], row[9]};
      t = 0; k = 0;
      for (int i = 0; i < 11; i++) if (i != 2 && i != 9) begin t[k] = row[i]; k++; end
      ar = t & ((1 << AR) - 1);
      if (busy_cnt > 0) begin
         m_cache[(f_bank << COL_W) | fill_idx] = m_arr[aidx(f_bank, f_arow, fill_idx)];
         fill_idx++;
         busy_cnt--;
      end else if (r && s) begin
         h = m_val[b] && (m_tag[b] == 9'(t));
         e_hit = h; e_miss = !h;
         if (w) begin
            m_arr[aidx(b, ar, col)] = wd;
            if (h) m_cache[(b << COL_W) | col] = wd;
         end else if (h) begin
            e_rv = 1; e_rdata = m_cache[(b << COL_W) | col];
         end else begin
            e_fill = 1; m_tag[b] = 9'(t); m_val[b] = 1;
            busy_cnt = WORDS; fill_idx = 0; f_bank = b; f_arow = ar;
         end
      end
   endtask

   task automatic step(input bit r, input bit s, input bit w,
                       input int b, input int t, input int c, input logic [35:0] wd);
      req_valid = r; sel = s; we = w;
      row_addr = mkrow(b, t); col_addr = 9'(c); wdata = wd;
      model(r, s, w, row_addr, col_addr, wd);
      @(negedge clk);
      compare();
   endtask

   task automatic idle_to_ready();
      for (int n = 0; n < WORDS + 4 && busy_cnt > 0; n++) step(0, 0, 0, 0, 0, 0, '0);
      step(0, 0, 0, 0, 0, 0, '0);
   endtask

   function automatic logic [35:0] pat(input int b, input int ar, input int c);
      return 36'(SEED + MUL * 64'(aidx(b, ar, c)));
   endfunction

   initial begin
      #(150000 * 5);
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int b = 0; b < 4; b++)
         for (int ar = 0; ar < (1 << AR); ar++)
            for (int c = 0; c < WORDS; c++) m_arr[aidx(b, ar, c)] = pat(b, ar, c);
      for (int b = 0; b < 4; b++) begin m_val[b] = 0; m_tag[b] = '0; end
      e_hit = 0; e_miss = 0; e_fill = 0; e_ill = 0; e_rv = 0; e_rdata = '0;
      // R2: outputs quiet in reset
      repeat (3) @(negedge clk);
      chk("R2", "busy in reset", 64'(busy), 0);
      chk("R2", "hit|miss in reset", 64'(hit | miss | fill_req | illegal | rdata_valid), 0);
      rst_n = 1'b1;
      // R2/R4/R10: first read misses, fill, then hit returns initial pattern
      step(1, 1, 0, 0, 5, 3, '0);
      idle_to_ready();
      step(1, 1, 0, 0, 5, 3, '0);
      chk("R10", "pattern word", 64'(rdata), 64'(pat(0, 1, 3)));
      // R1: each bank combination, tag extremes, last column
      for (int b = 1; b < 4; b++) begin
         step(1, 1, 0, b, 9'h1FF, 511, '0);
         idle_to_ready();
         step(1, 1, 0, b, 9'h1FF, 511, '0);
      end
      // R5: bank 0 still hits
      step(1, 1, 0, 0, 5, 3, '0);
      chk("R5", "bank0 kept", 64'(hit), 1);
      // R7: write hit, read back
      step(1, 1, 1, 0, 5, 3, 36'hABCDE1234);
      step(1, 1, 0, 0, 5, 3, '0);
      // R6: write miss to an aliased tag leaves bank 0 cache untouched
      step(1, 1, 1, 0, 7, 3, 36'h123456789);
      step(1, 1, 0, 0, 5, 3, '0);
      chk("R6", "cache kept", 64'(rdata), 64'h0ABCDE1234);
      step(1, 1, 0, 0, 7, 3, '0);
      // R9: requests during the fill are ignored
      step(1, 1, 1, 1, 9'h1FF, 4, 36'hFFFFFFFFF);
      step(1, 1, 0, 2, 3, 4, '0);
      idle_to_ready();
      step(1, 1, 0, 0, 7, 3, '0);
      chk("R7", "refill carries write", 64'(rdata), 64'h123456789);
      step(1, 1, 0, 1, 9'h1FF, 4, '0);
      // R8: strobe without select
      step(1, 0, 1, 0, 7, 3, 36'h0);
      step(1, 1, 0, 0, 7, 3, '0);
      chk("R8", "ignored write", 64'(rdata), 64'h123456789);
      // mixed random traffic
      for (int n = 0; n < 4000; n++)
         step($urandom_range(0, 3) != 0, $urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1,
              $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 7),
              {4'h0, 32'($urandom)});
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule